// File: doc/BRIEF.md
# Cascadable First-Word-Fall-Through Queue Chain

This block is a queue stage that presents the oldest stored word at its outputs as soon as the word arrives, with no read request. Identical stages are wired in series on one shared clock, so depth can be added without any glue logic. Each stage has two active-low flags. The output-ready flag of one stage is the write enable of the next stage. The input-ready flag of a stage is the read enable of the stage before it. A word moves between two neighbours on every clock edge where the upstream stage holds a word and the downstream stage has room. Each stage makes that decision by itself, from the same two flags.

The wrapper builds a chain of `N_STAGES` stages and exposes only the outer write side and the outer read side. Each stage has a storage array of `DEPTH` words and one output register. A stage therefore holds `DEPTH+1` words, and the chain holds the sum over all its stages. Inside a stage, the two pointers reach the opposite side through short register delays. Because of this, the first word into an empty chain and the first free slot in a full chain take a fixed number of cycles per stage to cross it. After that, data streams at one word per clock.

Top module: `fwft_chain`

## Requirements
- R1: A word written into an empty chain appears on `rd_data` with `out_rdy_n` low, without any read request. While `rd_en_n` stays high, `out_rdy_n` stays low and `rd_data` holds the same word.
- R2: A write is taken on a rising edge where `wr_en_n` and `in_rdy_n` are both low. A read is taken on a rising edge where `rd_en_n` and `out_rdy_n` are both low. Words leave the chain in the order they were taken.
- R3: The chain is empty and a single word is taken at edge e. `out_rdy_n` is first low after edge e + 4*N_STAGES - 1.
- R4: Every stage of the chain is full and a single word is read at edge r. `in_rdy_n` is first low after edge r + 3*N_STAGES - 1.
- R5: With no reads, the chain takes exactly N_STAGES*(DEPTH+1) words before `in_rdy_n` stays high.
- R6: A write presented while `in_rdy_n` is high is ignored. It adds no word and does not disturb the stored words.
- R7: A read presented while `out_rdy_n` is high is ignored. Words written afterwards still come out complete and in order.
- R8: With DEPTH >= 8, writes presented on every cycle and reads presented on every cycle, the chain takes one write and delivers one word on every clock once the first word has arrived.
- R9: While `rst_n` is sampled low on a rising edge, every stage is emptied. After that edge `out_rdy_n` is high and `in_rdy_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared transfer clock for every stage |
| rst_n | input | 1 | Synchronous master reset, active low |
| wr_data | input | DW | Word offered to the first stage |
| wr_en_n | input | 1 | Write request to the first stage, active low |
| in_rdy_n | output | 1 | Low when the first stage has a free location |
| rd_data | output | DW | Word presented by the last stage |
| rd_en_n | input | 1 | Read request to the last stage, active low |
| out_rdy_n | output | 1 | Low when the last stage presents a valid word |

## Verification
The hardest condition to reach from the ports is a chain in which every stage is full at once. It is needed to measure how long the first free slot takes to travel back to the front. The stimulus holds the outer write request low for far longer than the total capacity needs, with no reads. The count of accepted writes is checked against the capacity. The extra offered writes then act as the ignored-write stimulus. A single read starts the free-slot measurement. A full drain then confirms that no ignored write slipped into the stored data.

// File: rtl/fwft_chain_pkg.sv
package fwft_chain_pkg;

  // Occupancy between two wrapping pointers of pw bits.
  function automatic int unsigned ptr_gap(int unsigned wp, int unsigned rp, int unsigned pw);
    int unsigned mask;
    mask = (32'd1 << pw) - 32'd1;
    return (wp - rp) & mask;
  endfunction

  function automatic logic gap_full(int unsigned wp, int unsigned rp, int unsigned pw,
                                    int unsigned depth);
    return ptr_gap(wp, rp, pw) == depth;
  endfunction

  function automatic logic gap_nonzero(int unsigned wp, int unsigned rp, int unsigned pw);
    return ptr_gap(wp, rp, pw) != 0;
  endfunction

endpackage

// File: rtl/fwft_stage_ram.sv
module fwft_stage_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/fwft_stage.sv
module fwft_stage
  import fwft_chain_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen_n,
  output logic          ir_n,
  output logic [DW-1:0] dout,
  input  logic          ren_n,
  output logic          or_n
);

  // Write side state
  logic [PW-1:0] wr_ptr, wr_ptr_nxt, rptr_seen;
  logic          full_q;
  // Read side state
  logic [PW-1:0] rd_ptr, wptr_d1, wptr_seen;
  logic          valid_q;
  logic [DW-1:0] out_q, ram_q;

  // Named internal events
  logic wr_evt;    // word stored in the array
  logic take_evt;  // outer read of the presented word
  logic ram_avail; // read side sees a stored word
  logic load_evt;  // array word moved into the output register

  assign wr_evt     = !wen_n && !full_q;
  assign wr_ptr_nxt = wr_ptr + PW'(wr_evt);
  assign take_evt   = !ren_n && valid_q;
  assign ram_avail  = gap_nonzero(32'(wptr_seen), 32'(rd_ptr), PW);
  assign load_evt   = ram_avail && (!valid_q || take_evt);

  fwft_stage_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_evt),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (din),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (ram_q)
  );

  // Write side: the read pointer arrives one cycle late, and the full flag is registered.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rptr_seen <= '0;
      full_q    <= 1'b0;
    end else begin
      wr_ptr    <= wr_ptr_nxt;
      rptr_seen <= rd_ptr;
      full_q    <= gap_full(32'(wr_ptr_nxt), 32'(rptr_seen), PW, DEPTH);
    end
  end

  // Read side: the write pointer arrives two cycles late and feeds the output register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wptr_d1   <= '0;
      wptr_seen <= '0;
      valid_q   <= 1'b0;
      out_q     <= '0;
    end else begin
      wptr_d1   <= wr_ptr;
      wptr_seen <= wptr_d1;
      if (load_evt) begin
        out_q   <= ram_q;
        rd_ptr  <= rd_ptr + PW'(1);
        valid_q <= 1'b1;
      end else if (take_evt) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign ir_n = full_q;
  assign or_n = !valid_q;
  assign dout = out_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_gap(32'(wr_ptr), 32'(rd_ptr), PW) <= DEPTH); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!or_n && ren_n) |=> (!or_n && $stable(dout))); // R1

  AST_VALID_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(or_n) |-> $past(ram_avail)); // R7

  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rst_n |=> (or_n && !ir_n)); // R9

endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  parameter int N_STAGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en_n,
  output logic          in_rdy_n,
  output logic [DW-1:0] rd_data,
  input  logic          rd_en_n,
  output logic          out_rdy_n
);

  logic [DW-1:0]       link_d [N_STAGES+1];
  logic [N_STAGES-1:0] or_w;
  logic [N_STAGES-1:0] ir_w;

  assign link_d[0] = wr_data;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic wen_k, ren_k;
    if (k == 0) begin : g_head
      assign wen_k = wr_en_n;
    end else begin : g_mid_w
      assign wen_k = or_w[k-1];
    end
    if (k == N_STAGES - 1) begin : g_tail
      assign ren_k = rd_en_n;
    end else begin : g_mid_r
      assign ren_k = ir_w[k+1];
    end

    fwft_stage #(.DW(DW), .DEPTH(DEPTH)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (link_d[k]),
      .wen_n (wen_k),
      .ir_n  (ir_w[k]),
      .dout  (link_d[k+1]),
      .ren_n (ren_k),
      .or_n  (or_w[k])
    );
  end

  assign in_rdy_n  = ir_w[0];
  assign out_rdy_n = or_w[N_STAGES-1];
  assign rd_data   = link_d[N_STAGES];

endmodule

// File: tb/fwft_chain_bench.sv
`timescale 1ns/1ps
module fwft_chain_bench;

  localparam int DW  = 8;
  localparam int DEP = 8;
  localparam int NS  = 3;
  localparam int CAP = NS * (DEP + 1);

  logic clk = 1'b0;
  logic rst_n, wen_n, ren_n;
  logic [DW-1:0] din;
  logic ir_n, or_n;
  logic [DW-1:0] dout;

  always #10 clk = ~clk;

  fwft_chain #(.DW(DW), .DEPTH(DEP), .N_STAGES(NS)) u_fwft_chain (
    .clk(clk), .rst_n(rst_n), .wr_data(din), .wr_en_n(wen_n), .in_rdy_n(ir_n),
    .rd_data(dout), .rd_en_n(ren_n), .out_rdy_n(or_n)
  );

  int vectors = 0;
  int fails   = 0;
  logic [DW-1:0] sb [256];
  int head = 0, tail = 0;
  logic [DW-1:0] seq = 8'h10;
  int nwr, nrd;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, and account for what the next rising edge takes.
  task automatic step(bit wr, bit rd, string req);
    @(negedge clk);
    wen_n = !wr;
    ren_n = !rd;
    din   = seq;
    seq   = seq + 8'd1;
    if (wr && !ir_n) begin
      sb[tail[7:0]] = din;
      tail++;
      nwr++;
    end
    if (rd && !or_n) begin
      chk(head < tail, req, head, tail);
      chk(dout == sb[head[7:0]], req, int'(dout), int'(sb[head[7:0]]));
      head++;
      nrd++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    head = 0; tail = 0;
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int first;
    rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    chk(or_n == 1'b1, "R9 reset out_rdy_n", int'(or_n), 1);
    chk(ir_n == 1'b0, "R9 reset in_rdy_n", int'(ir_n), 0);
    rst_n = 1'b1;

    // R3 / R1: first-word latency and fall-through
    nwr = 0; nrd = 0;
    step(1, 0, "R2");
    first = -1;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      wen_n = 1'b1;
      if (!or_n && first < 0) first = k;
    end
    chk(first == 4 * NS - 1, "R3 first-word latency", first, 4 * NS - 1);
    chk(or_n == 1'b0, "R1 word held valid", int'(or_n), 0);
    chk(dout == sb[0], "R1 word on output without read", int'(dout), int'(sb[0]));
    step(0, 1, "R2 read order");
    step(0, 0, "R2");
    chk(or_n == 1'b1, "R2 empty after read", int'(or_n), 1);

    // R7: reads on an empty chain are ignored
    for (int i = 0; i < 10; i++) step(0, 1, "R7");
    chk(nrd == 1, "R7 no read taken when empty", nrd, 1);
    for (int i = 0; i < 3; i++) step(1, 0, "R7");
    for (int i = 0; i < 20; i++) step(0, 0, "R7");
    for (int i = 0; i < 10; i++) step(0, 1, "R7 data after ignored reads");
    chk(nrd == 4, "R7 word count after ignored reads", nrd, 4);
    chk(or_n == 1'b1, "R7 empty at end", int'(or_n), 1);

    // R8: streaming throughput
    nwr = 0; nrd = 0;
    for (int i = 0; i < 200; i++) begin
      if (i == 40) nrd = 0;
      step(1, 1, "R8 stream order");
    end
    chk(nwr == 200, "R8 write every cycle", nwr, 200);
    chk(nrd == 160, "R8 read every cycle", nrd, 160);
    for (int i = 0; i < 40; i++) step(0, 1, "R8 drain");
    chk(head == tail, "R8 all words out", head, tail);
    chk(or_n == 1'b1, "R8 empty after drain", int'(or_n), 1);

    // R5 / R6: fill, then keep offering writes
    do_reset();
    nwr = 0; nrd = 0;
    for (int i = 0; i < 120; i++) step(1, 0, "R5");
    chk(nwr == CAP, "R5 capacity", nwr, CAP);
    chk(ir_n == 1'b1, "R6 in_rdy_n high when full", int'(ir_n), 1);

    // R4: free-slot latency from a full chain
    step(0, 1, "R4 read from full chain");
    first = -1;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      ren_n = 1'b1;
      if (!ir_n && first < 0) first = k;
    end
    chk(first == 3 * NS - 1, "R4 free-slot latency", first, 3 * NS - 1);
    for (int i = 0; i < 80; i++) step(0, 1, "R6 stored words intact");
    chk(nrd == CAP, "R6 no extra word from ignored writes", nrd, CAP);
    chk(or_n == 1'b1, "R6 empty after drain", int'(or_n), 1);

    // R9: reset in the middle of traffic
    for (int i = 0; i < 5; i++) step(1, 0, "R9");
    for (int i = 0; i < 20; i++) step(0, 0, "R9");
    do_reset();
    @(negedge clk);
    chk(or_n == 1'b1, "R9 mid reset out_rdy_n", int'(or_n), 1);
    chk(ir_n == 1'b0, "R9 mid reset in_rdy_n", int'(ir_n), 0);
    nrd = 0;
    step(1, 0, "R9");
    for (int i = 0; i < 20; i++) step(0, 0, "R9");
    step(0, 1, "R9 first word after reset");
    chk(nrd == 1, "R9 one word after reset", nrd, 1);
    step(0, 0, "R9");
    chk(or_n == 1'b1, "R9 chain empty again", int'(or_n), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule